// File: doc/BRIEF.md
# Dual Key-Lock Controller

This block is a small register-mapped controller that guards two protected asset regions. One is a customer lock and the other is a recovery lock. Each lock compares against its own 128-bit reference key, which arrives on an input port. Software picks a lock by writing a selection code. It then writes four 32-bit key words. The lock opens only when all 128 bits match that lock's reference. A wrong or badly sequenced attempt closes the selected lock.

A status register shows which locks are open. The two locks react differently to a status read. A read returns the current state. Straight after that read the recovery lock closes by itself, while the customer lock keeps its state. Both lock states also leave the block as level outputs, so neighbouring logic can gate the protected regions.

Attempts are tracked by a key-sequence state machine with six states:
- `SEQ_NOSEL`: no lock has been selected since reset.
- `SEQ_EMPTY`: a lock is selected and no key word has been written yet.
- `SEQ_HAVE0`, `SEQ_HAVE1`, `SEQ_HAVE2`: words 0, 0–1 or 0–2 have been collected in order.
- `SEQ_SPOILED`: the sequence broke.

The transitions are:
- A valid selection write moves any state to `SEQ_EMPTY`.
- Writing the next expected word advances `EMPTY→HAVE0→HAVE1→HAVE2`.
- Writing key word 3 from any selected state ends the attempt. `HAVE2` and the three earlier in-order states return to `EMPTY`, and `SPOILED` stays in `SPOILED`.
- Any other key word write moves to `SPOILED`.
- In `SEQ_NOSEL`, key writes do nothing.

Top module: `klc_dual_lock`

## Requirements
- R1: After reset both locks are closed. The status register (address 1) reads 0, and the selection register (address 0) reads 0.
- R2: Writing 32'h0000_0001 to address 0 selects the customer lock. Writing 32'h4000_0000 selects the recovery lock. Address 0 reads back the code of the selected lock.
- R3: A write to address 0 with any other value is ignored. The selection and any key sequence in progress are unchanged.
- R4: A write of key word 3 (address 7) opens the selected lock only under two conditions. First, the words at addresses 4, 5 and 6 (key words 0, 1, 2) must have been written in that order since the last valid selection write. Second, {word3, word2, word1, word0} must equal that lock's 128-bit reference, with word 0 in bits 31:0.
- R5: A key word 3 write whose 128-bit key differs from the reference closes the selected lock, even if it was open. The other lock is untouched.
- R6: A key word written out of order counts as a mismatch. So do a repeated word and a skipped word. The sequence stays spoiled until the next valid selection write.
- R7: The status register has bit 0 set when the customer lock is open and bit 30 set when the recovery lock is open. All other bits are 0. Read data appears with `bus_rvalid` high in the cycle after the read request.
- R8: A status read returns the state before the read. The recovery lock is then closed, and the customer lock keeps its state.
- R9: The key word registers (addresses 4 to 7) read back as zero.
- R10: A key word 3 write before any lock has been selected since reset has no effect on either lock.
- R11: After an attempt finishes, a new word 0..3 series on the same selection is a fresh attempt. No selection rewrite is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| ref_key_cust | input | 128 | Customer lock reference key |
| ref_key_rcvr | input | 128 | Recovery lock reference key |
| cust_open | output | 1 | Customer lock open |
| rcvr_open | output | 1 | Recovery lock open |

## Verification
The assertions rest on two assumptions about the inputs:
- The bus carries at most one access per cycle.
- The reference keys stay constant while an attempt is in flight. This means an opening can be traced back to a single key word 3 write in the previous cycle.

The stimulus respects both assumptions. It issues one access per clock and ties both reference keys to fixed values for the whole run. It then reaches every sequence state by ordering its key writes:
- in order,
- out of order,
- across an ignored selection write,
- with no selection at all.

// File: rtl/klc_pkg.sv
package klc_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int KEY_WORDS = 4;
    localparam int KEY_W     = DATA_W * KEY_WORDS;
    localparam int N_LOCKS   = 2;
    localparam int IDX_W     = $clog2(KEY_WORDS);

    localparam int CUST_BIT = 0;
    localparam int RCVR_BIT = 30;

    localparam logic [DATA_W-1:0] CUST_CODE = DATA_W'(1) << CUST_BIT;
    localparam logic [DATA_W-1:0] RCVR_CODE = DATA_W'(1) << RCVR_BIT;

    localparam logic [ADDR_W-1:0] A_SEL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_KEY3 = 3'd7;

    localparam int LK_IDX_CUST = 0;
    localparam int LK_IDX_RCVR = 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CUST = 2'd1,
        SEL_RCVR = 2'd2
    } lock_sel_e;

    typedef enum logic [2:0] {
        SEQ_NOSEL   = 3'd0,
        SEQ_EMPTY   = 3'd1,
        SEQ_HAVE0   = 3'd2,
        SEQ_HAVE1   = 3'd3,
        SEQ_HAVE2   = 3'd4,
        SEQ_SPOILED = 3'd5
    } seq_state_e;
endpackage

// File: rtl/klc_regif.sv
module klc_regif
    import klc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   sel_code,
    input  logic [N_LOCKS-1:0]  lk_open,
    output logic                sel_wr,
    output logic                stat_rd,
    output logic                key_wr,
    output logic [IDX_W-1:0]    key_idx,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid
);
    logic              is_key_addr;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] rd_mux;

    // address decode into single-cycle events
    always_comb begin
        is_key_addr = bus_addr[ADDR_W-1];
        sel_wr      = bus_en &  bus_we & (bus_addr == A_SEL);
        stat_rd     = bus_en & ~bus_we & (bus_addr == A_STAT);
        key_wr      = bus_en &  bus_we & is_key_addr;
        key_idx     = bus_addr[IDX_W-1:0];
        wdata       = bus_wdata;
    end

    // status word built from the per-lock states
    always_comb begin
        stat_word           = '0;
        stat_word[CUST_BIT] = lk_open[LK_IDX_CUST];
        stat_word[RCVR_BIT] = lk_open[LK_IDX_RCVR];
    end

    // key words are write-only: their addresses fall to the zero default
    always_comb begin
        unique case (bus_addr)
            A_SEL:   rd_mux = sel_code;
            A_STAT:  rd_mux = stat_word;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_en & ~bus_we;
            if (bus_en && !bus_we) begin
                bus_rdata <= rd_mux;
            end
        end
    end
endmodule

// File: rtl/klc_key_seq.sv
module klc_key_seq
    import klc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_wr,
    input  logic                key_wr,
    input  logic [IDX_W-1:0]    key_idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [KEY_W-1:0]    ref_key_cust,
    input  logic [KEY_W-1:0]    ref_key_rcvr,
    output logic [N_LOCKS-1:0]  attempt,
    output logic                match,
    output logic [DATA_W-1:0]   sel_code
);
    localparam int HELD_WORDS = KEY_WORDS - 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_WORDS - 1);

    seq_state_e        state_q, state_d;
    lock_sel_e         sel_q, sel_d;
    logic              sel_valid;
    logic              last_wr;
    logic [DATA_W-1:0] held_q [HELD_WORDS];
    logic [KEY_W-1:0]  cand_key;
    logic [KEY_W-1:0]  ref_key;

    assign sel_valid = sel_wr & ((wdata == CUST_CODE) | (wdata == RCVR_CODE));
    assign last_wr   = key_wr & (key_idx == LAST_IDX);

    // holding registers for the leading key words
    for (genvar w = 0; w < HELD_WORDS; w++) begin : g_held
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q[w] <= '0;
            end else if (key_wr && (key_idx == IDX_W'(w))) begin
                held_q[w] <= wdata;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_NOSEL;
            sel_q   <= SEL_NONE;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        if (sel_valid) begin
            state_d = SEQ_EMPTY;
            sel_d   = (wdata == CUST_CODE) ? SEL_CUST : SEL_RCVR;
        end else if (key_wr) begin
            unique case (state_q)
                SEQ_NOSEL:   state_d = SEQ_NOSEL;
                SEQ_EMPTY:   state_d = (key_idx == 2'd0) ? SEQ_HAVE0 :
                                       last_wr ? SEQ_EMPTY : SEQ_SPOILED;
                SEQ_HAVE0:   state_d = (key_idx == 2'd1) ? SEQ_HAVE1 :
                                       last_wr ? SEQ_EMPTY : SEQ_SPOILED;
                SEQ_HAVE1:   state_d = (key_idx == 2'd2) ? SEQ_HAVE2 :
                                       last_wr ? SEQ_EMPTY : SEQ_SPOILED;
                SEQ_HAVE2:   state_d = last_wr ? SEQ_EMPTY : SEQ_SPOILED;
                SEQ_SPOILED: state_d = SEQ_SPOILED;
                default:     state_d = SEQ_SPOILED;
            endcase
        end
    end

    // outputs: attempt strobe per lock, match result, selection readback
    always_comb begin
        cand_key = {wdata, held_q[2], held_q[1], held_q[0]};
        ref_key  = (sel_q == SEL_RCVR) ? ref_key_rcvr : ref_key_cust;
        match    = (state_q == SEQ_HAVE2) && (cand_key == ref_key);
        attempt  = '0;
        sel_code = '0;
        unique case (sel_q)
            SEL_CUST: begin
                attempt[LK_IDX_CUST] = last_wr;
                sel_code             = CUST_CODE;
            end
            SEL_RCVR: begin
                attempt[LK_IDX_RCVR] = last_wr;
                sel_code             = RCVR_CODE;
            end
            default: begin
                attempt  = '0;
                sel_code = '0;
            end
        endcase
    end
endmodule

// File: rtl/klc_lock_cell.sv
module klc_lock_cell #(
    parameter bit SELF_CLOSE_ON_READ = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic attempt,
    input  logic match,
    input  logic stat_rd,
    output logic is_open
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
        end else if (attempt) begin
            is_open <= match;
        end else if (SELF_CLOSE_ON_READ && stat_rd) begin
            is_open <= 1'b0;
        end
    end
endmodule

// File: rtl/klc_dual_lock.sv
module klc_dual_lock
    import klc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_en,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rvalid,
    input  logic [KEY_W-1:0]           ref_key_cust,
    input  logic [KEY_W-1:0]           ref_key_rcvr,
    output logic                       cust_open,
    output logic                       rcvr_open
);
    logic               sel_wr, stat_rd, key_wr, match;
    logic [IDX_W-1:0]   key_idx;
    logic [DATA_W-1:0]  wdata, sel_code;
    logic [N_LOCKS-1:0] attempt, lk_open;

    klc_regif u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .sel_code   (sel_code),
        .lk_open    (lk_open),
        .sel_wr     (sel_wr),
        .stat_rd    (stat_rd),
        .key_wr     (key_wr),
        .key_idx    (key_idx),
        .wdata      (wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    klc_key_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_wr       (sel_wr),
        .key_wr       (key_wr),
        .key_idx      (key_idx),
        .wdata        (wdata),
        .ref_key_cust (ref_key_cust),
        .ref_key_rcvr (ref_key_rcvr),
        .attempt      (attempt),
        .match        (match),
        .sel_code     (sel_code)
    );

    // lock 0 keeps its state on a status read, lock 1 closes itself
    for (genvar g = 0; g < N_LOCKS; g++) begin : g_lock
        klc_lock_cell #(
            .SELF_CLOSE_ON_READ (g == LK_IDX_RCVR)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .attempt (attempt[g]),
            .match   (match),
            .stat_rd (stat_rd),
            .is_open (lk_open[g])
        );
    end

    assign cust_open = lk_open[LK_IDX_CUST];
    assign rcvr_open = lk_open[LK_IDX_RCVR];
endmodule

// File: rtl/klc_dual_lock_chk.sv
module klc_dual_lock_chk
    import klc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              cust_open,
    input logic              rcvr_open
);
    logic stat_req, key3_wr, key_rd;
    assign stat_req = bus_en && !bus_we && (bus_addr == A_STAT);
    assign key3_wr  = bus_en && bus_we && (bus_addr == A_KEY3);
    assign key_rd   = bus_en && !bus_we && bus_addr[ADDR_W-1];

    AST_RESET_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!cust_open && !rcvr_open)); // R1

    AST_CUST_OPENS_ON_KEY3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cust_open) |-> $past(key3_wr)); // R4

    AST_RCVR_OPENS_ON_KEY3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rcvr_open) |-> $past(key3_wr)); // R4

    AST_CUST_FALLS_ON_KEY3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cust_open) |-> $past(key3_wr)); // R5

    AST_RCVR_CLOSES_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        stat_req |=> !rcvr_open); // R8

    AST_CUST_HOLDS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        stat_req |=> $stable(cust_open)); // R8

    AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        key_rd |=> (bus_rvalid && bus_rdata == '0)); // R9
endmodule

bind klc_dual_lock klc_dual_lock_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .cust_open  (cust_open),
    .rcvr_open  (rcvr_open)
);

// File: tb/klc_dual_lock_tb.sv
module klc_dual_lock_tb;
    import klc_pkg::*;

    localparam logic [KEY_W-1:0] KC = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [KEY_W-1:0] KR = 128'hA5A5_0F0F_1357_9BDF_2468_ACE0_C3C3_5A5A;
    localparam logic [KEY_W-1:0] KBAD = KC ^ (128'h1 << 77);
    localparam logic [31:0] ST_C = 32'h0000_0001;
    localparam logic [31:0] ST_R = 32'h4000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic bus_rvalid, cust_open, rcvr_open;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    klc_dual_lock u_dut (
        .clk (clk), .rst_n (rst_n), .bus_en (bus_en), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_rvalid (bus_rvalid), .ref_key_cust (KC), .ref_key_rcvr (KR),
        .cust_open (cust_open), .rcvr_open (rcvr_open)
    );

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read data: got %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic key(input logic [KEY_W-1:0] k);
        for (int w = 0; w < 4; w++) wr(3'(4 + w), k[w*32 +: 32]);
    endtask

    task automatic port(input logic c, input logic r, input string t);
        n_chk++;
        if (cust_open !== c || rcvr_open !== r) begin
            n_bad++;
            $display("FAIL %s: got c=%b r=%b expected c=%b r=%b", t, cust_open, rcvr_open, c, r);
        end
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1 reset state
                port(1'b0, 1'b0, "R1 ports after reset");
                rd(3'd1, 32'h0, "R1 status after reset");
                rd(3'd0, 32'h0, "R1 selection after reset");
                // R10 key with no selection
                key(KC);
                port(1'b0, 1'b0, "R10 key before selection");
                // R2 select customer, R4 correct key
                wr(3'd0, ST_C);
                rd(3'd0, ST_C, "R2 customer selection readback");
                key(KC);
                port(1'b1, 1'b0, "R4 customer opened");
                rd(3'd1, ST_C, "R7 status shows customer");
                rd(3'd1, ST_C, "R8 customer kept after read");
                // R3 invalid code ignored
                wr(3'd0, 32'h0000_0003);
                rd(3'd0, ST_C, "R3 invalid code ignored");
                // recovery open, self-closes on read
                wr(3'd0, ST_R);
                rd(3'd0, ST_R, "R2 recovery selection readback");
                key(KR);
                port(1'b1, 1'b1, "R4 recovery opened");
                rd(3'd1, ST_C | ST_R, "R7 status both open");
                rd(3'd1, ST_C, "R8 recovery closed by read");
                port(1'b1, 1'b0, "R8 ports after read");
                // R9 key registers read zero
                rd(3'd4, 32'h0, "R9 key word 0 reads zero");
                rd(3'd7, 32'h0, "R9 key word 3 reads zero");
                // R5 wrong key closes customer, recovery untouched
                key(KR);
                wr(3'd0, ST_C);
                key(KBAD);
                port(1'b0, 1'b1, "R5 wrong key closed customer only");
                rd(3'd1, ST_R, "R5 status after wrong key");
                // R6 out-of-order spoils until reselect
                wr(3'd0, ST_C);
                wr(3'd4, KC[31:0]);
                wr(3'd6, KC[95:64]);
                key(KC);
                port(1'b0, 1'b0, "R6 spoiled sequence stays closed");
                wr(3'd0, ST_C);
                key(KC);
                port(1'b1, 1'b0, "R6 reselect clears spoil");
                // R11 fresh attempts without reselect
                key(KBAD);
                port(1'b0, 1'b0, "R11 fresh wrong attempt closes");
                key(KC);
                port(1'b1, 1'b0, "R11 fresh correct attempt opens");
                // R3 invalid code mid-sequence keeps progress
                key(KBAD);
                wr(3'd4, KC[31:0]);
                wr(3'd5, KC[63:32]);
                wr(3'd0, 32'hFFFF_FFFF);
                wr(3'd6, KC[95:64]);
                wr(3'd7, KC[127:96]);
                port(1'b1, 1'b0, "R3 invalid code mid-sequence ignored");
                repeat (3) @(negedge clk);
                if (exp_q.size() != 0) begin
                    n_bad++;
                    $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
                end
            end
            begin
                repeat (5000) @(negedge clk);
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule